// File: doc/BRIEF.md
# Soft-Ramp Stereo Volume Attenuator

This block sits in a stereo PCM sample path. It scales each signed 24-bit sample of a left/right pair by an attenuation set from a 7-bit code per channel. Codes run from 0 dB to 94 dB in 1 dB steps. Any code of 95 or more silences the channel. The gain is a six-entry fractional mantissa multiplied with the sample, followed by a right shift of one bit per 6 dB group. The product is rounded back to 24 bits.

The attenuation a channel actually uses is its "applied" code. This code follows the target code in one of four ways, and one mode input selects the way for both channels. The applied code can jump to the target at once. It can jump only at a zero crossing of that channel's signal. It can walk toward the target by 1 dB per sample. It can also walk by 1 dB but take each step only at a zero crossing. The two zero-crossing modes fall back to a timeout: if no crossing arrives within 512 pending samples, the change is made anyway. Each channel keeps its own applied code, its own previous-sample sign and its own timeout counter.

Top module: `vol_ramp_atten`

## Requirements
- R1: After reset, `out_valid_o` is 0, both outputs are 0, and both channels start with the applied code at 95 (muted). In mode 1, a first positive nonzero sample therefore produces 0.
- R2: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high. The outputs hold their values while `out_valid_o` is low.
- R3: For an applied code a below 95, let g = a/6 and r = a%6. The output is (x*M[r] + 2^(14+g)) shifted arithmetically right by 15+g, with M = {32768, 29205, 26029, 23198, 20675, 18427} for r = 0..5.
- R4: An applied code of 95 to 127 produces an output of exactly 0.
- R5: In mode 0 (direct), a new target code is used for the very sample it arrives with.
- R6: In mode 1 (zero-cross), the applied code changes to the target only on a sample that is zero, or whose sign bit 23 differs from the previous valid sample of that channel. That sample already uses the new code.
- R7: In modes 1 and 3, if a change stays pending without a crossing, the 512th consecutive pending sample applies it. The pending-sample count restarts whenever a change is applied.
- R8: In mode 2 (ramp), each valid sample moves the applied code by exactly 1 toward min(target, 95), and that sample uses the moved code.
- R9: In mode 3 (ramp at crossings), the applied code moves by 1 toward the target only on a crossing sample, or when the R7 timeout fires.
- R10: The two channels keep independent applied codes and crossing history, while sharing the mode.
- R11: Target changes made while `in_valid_i` is low have no effect. Only the target present with a valid sample counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 direct, 1 zero-cross, 2 ramp, 3 ramp at crossings |
| atten_l_i | input | 7 | Left target attenuation code in dB |
| atten_r_i | input | 7 | Right target attenuation code in dB |
| in_valid_i | input | 1 | Sample pair strobe |
| in_l_i | input | 24 | Left sample, two's complement |
| in_r_i | input | 24 | Right sample, two's complement |
| out_valid_o | output | 1 | Scaled pair valid, one cycle after input |
| out_l_o | output | 24 | Scaled left sample |
| out_r_o | output | 24 | Scaled right sample |

## Verification
A zero crossing and the expiry of the 512-sample wait can land on the same sample. The bench provokes this by feeding 511 same-sign pending samples and then a sign flip. That sample must take the new code once, and the wait counter must restart from zero. To judge the restart, the bench posts a fresh target right after the flip and feeds same-sign samples. The old gain must persist for exactly 511 of them, and the new gain must appear on the 512th.

// File: rtl/vol_pkg.sv
package vol_pkg;

    typedef enum logic [1:0] {
        VM_DIRECT     = 2'd0,
        VM_ZEROX      = 2'd1,
        VM_RAMP       = 2'd2,
        VM_RAMP_ZEROX = 2'd3
    } vol_mode_e;

    localparam int MANT_W    = 16;
    localparam int MANT_FRAC = 15;
    localparam int DB_PER_GRP = 6;

    // 10^(-r/20) in Q1.15, r = 0..5; a full 6 dB group is one right shift
    function automatic logic [MANT_W-1:0] db_mantissa(input logic [2:0] r);
        logic [MANT_W-1:0] m;
        case (r)
            3'd0:    m = 16'd32768;
            3'd1:    m = 16'd29205;
            3'd2:    m = 16'd26029;
            3'd3:    m = 16'd23198;
            3'd4:    m = 16'd20675;
            default: m = 16'd18427;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vol_step_ctl.sv
module vol_step_ctl
    import vol_pkg::*;
#(
    parameter int CODE_W     = 7,
    parameter int DATA_W     = 24,
    parameter int MUTE_CODE  = 95,
    parameter int ZC_TIMEOUT = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  vol_mode_e                mode_i,
    input  logic [CODE_W-1:0]        target_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic [CODE_W-1:0]        eff_o,
    output logic [CODE_W-1:0]        applied_o
);

    localparam int CNT_W = (ZC_TIMEOUT > 2) ? $clog2(ZC_TIMEOUT) : 1;
    localparam logic [CODE_W-1:0] MUTE_V    = CODE_W'(MUTE_CODE);
    localparam logic [CNT_W-1:0]  LAST_WAIT = CNT_W'(ZC_TIMEOUT - 1);

    typedef struct packed {
        logic [CODE_W-1:0] applied;
        logic              prev_neg;
        logic [CNT_W-1:0]  wcnt;
    } ch_state_t;

    ch_state_t st_d, st_q;

    logic [CODE_W-1:0] goal;
    logic [CODE_W-1:0] toward;
    logic              pending;
    logic              crossing;
    logic              timed_out;
    logic              gated;
    logic              stepped;
    logic              fire;

    always_comb begin
        st_d      = st_q;
        goal      = (target_i >= MUTE_V) ? MUTE_V : target_i;
        pending   = (goal != st_q.applied);
        crossing  = (sample_i == '0) || (sample_i[DATA_W-1] != st_q.prev_neg);
        timed_out = (st_q.wcnt == LAST_WAIT);
        toward    = (goal > st_q.applied) ? st_q.applied + 1'b1 : st_q.applied - 1'b1;
        gated     = (mode_i == VM_ZEROX) || (mode_i == VM_RAMP_ZEROX);
        stepped   = (mode_i == VM_RAMP) || (mode_i == VM_RAMP_ZEROX);
        fire      = !gated || crossing || timed_out;

        if (valid_i) begin
            st_d.prev_neg = sample_i[DATA_W-1];
            if (pending && fire) begin
                st_d.applied = stepped ? toward : goal;
                st_d.wcnt    = '0;
            end else if (pending) begin
                st_d.wcnt    = st_q.wcnt + 1'b1;
            end else begin
                st_d.wcnt    = '0;
            end
        end

        eff_o     = valid_i ? st_d.applied : st_q.applied;
        applied_o = st_q.applied;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.applied  <= MUTE_V;
            st_q.prev_neg <= 1'b0;
            st_q.wcnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vol_gain_scale.sv
module vol_gain_scale
    import vol_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int CODE_W    = 7,
    parameter int MUTE_CODE = 95
) (
    input  logic [CODE_W-1:0]        code_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic signed [DATA_W-1:0] scaled_o
);

    localparam int PROD_W = DATA_W + MANT_W + 1;
    localparam logic [CODE_W-1:0] MUTE_V = CODE_W'(MUTE_CODE);

    logic [CODE_W-1:0]        grp;
    logic [CODE_W-1:0]        rem;
    logic [5:0]               sh;
    logic signed [MANT_W:0]   mant_s;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        grp     = code_i / CODE_W'(DB_PER_GRP);
        rem     = code_i % CODE_W'(DB_PER_GRP);
        sh      = 6'(MANT_FRAC) + 6'(grp);
        mant_s  = $signed({1'b0, db_mantissa(3'(rem))});
        prod    = PROD_W'(sample_i) * PROD_W'(mant_s);
        rounded = prod + (PROD_W'(1) << (sh - 6'd1));
        shifted = rounded >>> sh;
        scaled_o = (code_i >= MUTE_V) ? '0 : shifted[DATA_W-1:0];
    end

endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten
    import vol_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int CODE_W     = 7,
    parameter int MUTE_CODE  = 95,
    parameter int ZC_TIMEOUT = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic [CODE_W-1:0]        atten_l_i,
    input  logic [CODE_W-1:0]        atten_r_i,
    input  logic                     in_valid_i,
    input  logic signed [DATA_W-1:0] in_l_i,
    input  logic signed [DATA_W-1:0] in_r_i,
    output logic                     out_valid_o,
    output logic signed [DATA_W-1:0] out_l_o,
    output logic signed [DATA_W-1:0] out_r_o
);

    localparam int NUM_CH = 2;

    logic [CODE_W-1:0]        tgt    [NUM_CH];
    logic [CODE_W-1:0]        eff    [NUM_CH];
    logic [CODE_W-1:0]        appl_q [NUM_CH];
    logic signed [DATA_W-1:0] smp    [NUM_CH];
    logic signed [DATA_W-1:0] scaled [NUM_CH];
    vol_mode_e                mode;

    assign mode   = vol_mode_e'(mode_i);
    assign tgt[0] = atten_l_i;
    assign tgt[1] = atten_r_i;
    assign smp[0] = in_l_i;
    assign smp[1] = in_r_i;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            vol_step_ctl #(
                .CODE_W    (CODE_W),
                .DATA_W    (DATA_W),
                .MUTE_CODE (MUTE_CODE),
                .ZC_TIMEOUT(ZC_TIMEOUT)
            ) u_ctl (
                .clk      (clk),
                .rst_n    (rst_n),
                .valid_i  (in_valid_i),
                .mode_i   (mode),
                .target_i (tgt[ch]),
                .sample_i (smp[ch]),
                .eff_o    (eff[ch]),
                .applied_o(appl_q[ch])
            );

            vol_gain_scale #(
                .DATA_W   (DATA_W),
                .CODE_W   (CODE_W),
                .MUTE_CODE(MUTE_CODE)
            ) u_scale (
                .code_i  (eff[ch]),
                .sample_i(smp[ch]),
                .scaled_o(scaled[ch])
            );
        end
    endgenerate

    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] l;
        logic signed [DATA_W-1:0] r;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid_i;
        if (in_valid_i) begin
            out_d.l = scaled[0];
            out_d.r = scaled[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid_o = out_q.valid;
    assign out_l_o     = out_q.l;
    assign out_r_o     = out_q.r;

endmodule

// File: rtl/vol_ramp_atten_chk.sv
module vol_ramp_atten_chk #(
    parameter int DATA_W    = 24,
    parameter int CODE_W    = 7,
    parameter int MUTE_CODE = 95
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               mode_i,
    input logic [CODE_W-1:0]        atten_l_i,
    input logic                     in_valid_i,
    input logic signed [DATA_W-1:0] in_l_i,
    input logic                     out_valid_o,
    input logic signed [DATA_W-1:0] out_l_o,
    input logic signed [DATA_W-1:0] out_r_o,
    input logic [CODE_W-1:0]        appl_l,
    input logic [CODE_W-1:0]        appl_r,
    input logic [CODE_W-1:0]        eff_l,
    input logic [CODE_W-1:0]        eff_r
);

    localparam logic [CODE_W-1:0] MUTE_V = CODE_W'(MUTE_CODE);

    function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
        logic signed [DATA_W:0] e;
        e = {v[DATA_W-1], v};
        return $unsigned((e < 0) ? -e : e);
    endfunction

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && $stable(out_l_o) && $stable(out_r_o)));

    a_r3_never_louder: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (mag(out_l_o) <= mag($past(in_l_i))));

    a_r4_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && eff_l >= MUTE_V) |=> (out_l_o == '0));

    a_r4_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && eff_r >= MUTE_V) |=> (out_r_o == '0));

    a_r5_direct_takes_target: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == 2'd0) |=>
            (appl_l == (($past(atten_l_i) >= MUTE_V) ? MUTE_V : $past(atten_l_i))));

    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i[1]) |=>
            ((appl_l == $past(appl_l)) || (appl_l == $past(appl_l) + 1'b1) ||
             (appl_l + 1'b1 == $past(appl_l))));

    a_r11_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(appl_l) && $stable(appl_r)));

endmodule

bind vol_ramp_atten vol_ramp_atten_chk #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .MUTE_CODE(MUTE_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .atten_l_i  (atten_l_i),
    .in_valid_i (in_valid_i),
    .in_l_i     (in_l_i),
    .out_valid_o(out_valid_o),
    .out_l_o    (out_l_o),
    .out_r_o    (out_r_o),
    .appl_l     (appl_q[0]),
    .appl_r     (appl_q[1]),
    .eff_l      (eff[0]),
    .eff_r      (eff[1])
);

// File: tb/vol_ramp_atten_test.sv
module vol_ramp_atten_test;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode;
    logic [6:0]        att_l, att_r;
    logic              in_valid;
    logic signed [23:0] in_l, in_r;
    logic              out_valid;
    logic signed [23:0] out_l, out_r;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vol_ramp_atten uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .atten_l_i  (att_l),
        .atten_r_i  (att_r),
        .in_valid_i (in_valid),
        .in_l_i     (in_l),
        .in_r_i     (in_r),
        .out_valid_o(out_valid),
        .out_l_o    (out_l),
        .out_r_o    (out_r)
    );

    typedef struct packed {
        logic [6:0]         code;
        logic signed [23:0] x;
        logic signed [23:0] y;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{7'd0,   24'sd1000,     24'sd1000},
        '{7'd1,   24'sd100000,   24'sd89127},
        '{7'd6,   24'sd100000,   24'sd50000},
        '{7'd7,   -24'sd100000,  -24'sd44563},
        '{7'd94,  24'sd8388607,  24'sd162},
        '{7'd95,  24'sd5000,     24'sd0},
        '{7'd127, -24'sd5000,    24'sd0},
        '{7'd0,   24'h800000,    24'h800000},
        '{7'd12,  -24'sd3,       -24'sd1},
        '{7'd3,   24'sd2000000,  24'sd1415894}
    };

    // R3 formula, written from the requirement text
    function automatic int ref_gain(int code, int x);
        int mt [6] = '{32768, 29205, 26029, 23198, 20675, 18427};
        longint p;
        int g, r;
        if (code >= 95) return 0;
        g = code / 6;
        r = code % 6;
        p = longint'(x) * longint'(mt[r]) + (longint'(1) << (14 + g));
        return int'(p >>> (15 + g));
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(int l, int r);
        in_l     = 24'(l);
        in_r     = 24'(r);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_chk(int l, int r, int el, int er, string req);
        push(l, r);
        check(req, int'(out_l), el);
        check(req, int'(out_r), er);
    endtask

    task automatic set_att(int l, int r);
        att_l = 7'(l);
        att_r = 7'(r);
    endtask

    initial begin
        rst_n = 1'b0; mode = 2'd1; att_l = '0; att_r = '0;
        in_valid = 1'b0; in_l = '0; in_r = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 out", int'(out_l), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: still muted, no crossing on a positive first sample
        push_chk(1000, 1000, 0, 0, "R1 muted start");
        check("R2 valid", int'(out_valid), 1);
        @(negedge clk);
        check("R2 idle", int'(out_valid), 0);
        check("R2 hold", int'(out_l), 0);
        // R6: sign flip applies the 0 dB target
        push_chk(-1000, -1000, -1000, -1000, "R6 crossing");

        // R7: timeout on the 512th pending sample
        mode = 2'd1; set_att(0, 0);
        push_chk(1000, 1000, 1000, 1000, "R6 no pending");
        set_att(6, 6);
        for (int k = 1; k <= 512; k++) begin
            push(1000, 1000);
            check("R7 timeout", int'(out_l), (k < 512) ? 1000 : 500);
        end

        // R7 with R6: crossing lands on the timeout sample
        set_att(0, 0);
        for (int k = 1; k <= 511; k++) begin
            push(1000, 1000);
            check("R7 wait", int'(out_r), 500);
        end
        push_chk(-1000, -1000, -1000, -1000, "R7 coincide");
        set_att(6, 6);
        for (int k = 1; k <= 512; k++) begin
            push(-1000, -1000);
            check("R7 restart", int'(out_l), (k < 512) ? -1000 : -500);
        end

        // R5: direct mode
        mode = 2'd0; set_att(12, 12);
        push_chk(1000, -1000, ref_gain(12, 1000), ref_gain(12, -1000), "R5 direct");

        // R3 and R4: gain table vectors
        for (int i = 0; i < NV; i++) begin
            set_att(int'(VT[i].code), int'(VT[i].code));
            push_chk(int'(VT[i].x), int'(VT[i].x), int'(VT[i].y), int'(VT[i].y),
                     (VT[i].code >= 7'd95) ? "R4 mute" : "R3 gain");
        end

        // R10: independent channels
        mode = 2'd0; set_att(0, 12);
        push_chk(1000, 1000, 1000, 250, "R10 direct");
        mode = 2'd1; set_att(6, 6);
        push_chk(-1000, 1000, -500, 250, "R10 zerox split");
        push_chk(-1000, 1000, -500, 250, "R10 zerox hold");

        // R8: ramp up and down
        mode = 2'd0; set_att(0, 0);
        push_chk(1000, 1000, 1000, 1000, "R8 preset");
        mode = 2'd2; set_att(3, 100);
        for (int k = 1; k <= 100; k++) begin
            push(1000, 1000);
            check("R8 ramp L", int'(out_l), ref_gain((k < 3) ? k : 3, 1000));
            check("R8 ramp R", int'(out_r), ref_gain((k < 95) ? k : 95, 1000));
        end
        set_att(0, 90);
        for (int k = 1; k <= 6; k++) begin
            push(1000, 1000);
            check("R8 down L", int'(out_l), ref_gain((3 - k > 0) ? 3 - k : 0, 1000));
            check("R8 down R", int'(out_r), ref_gain((95 - k > 90) ? 95 - k : 90, 1000));
        end

        // R11: target wiggle without valid
        set_att(40, 10);
        repeat (5) begin
            @(negedge clk);
            check("R2 idle valid", int'(out_valid), 0);
        end
        set_att(0, 90);
        push_chk(1000, 1000, 1000, ref_gain(90, 1000), "R11 ignored");

        // R9: ramp steps at crossings only
        mode = 2'd0; set_att(0, 0);
        push_chk(1000, 1000, 1000, 1000, "R9 preset");
        mode = 2'd3; set_att(2, 2);
        push_chk(1000, 1000, 1000, 1000, "R9 wait");
        push_chk(1000, 1000, 1000, 1000, "R9 wait");
        push_chk(-1000, -1000, ref_gain(1, -1000), ref_gain(1, -1000), "R9 step1");
        push_chk(-1000, -1000, ref_gain(1, -1000), ref_gain(1, -1000), "R9 hold");
        push_chk(1000, 1000, ref_gain(2, 1000), ref_gain(2, 1000), "R9 step2");
        push_chk(-1000, -1000, ref_gain(2, -1000), ref_gain(2, -1000), "R9 reached");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule